// File: doc/BRIEF.md
# 1-Wire Bit Slot Engine

This block is the master side of a single-wire open-drain link. Each accepted command produces exactly one bit time slot: write-one, write-zero or read. The slot is followed by a released recovery gap. The line is driven through one active-high `pull_low` output. An external open-drain cell turns that output into a pulled-low wire, and the pull-up resistor brings the wire high whenever nobody pulls.

A command carries a two-bit operation code and a speed select, regular or overdrive. It is taken in over a valid/ready handshake. The engine times every slot phase with one cycle counter. The counter limits come from a clock-frequency parameter, so the same RTL meets both speed classes at any clock that is a whole number of MHz. For a read, the wire is brought through a two-flop synchronizer and sampled at a fixed point after the slot starts. The bit is returned with a one-cycle completion pulse. Higher layers build the other functions out of these bit slots: reset/presence, byte assembly and search.

Top module: `ow_slot_engine`

## Requirements
- R1: After a synchronous reset, `cmd_ready` is 1, and both `pull_low` and `done` are 0.
- R2: A command is taken only on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` stays 0 from that edge until the cycle that carries `done`. While it is 0, the command inputs have no effect.
- R3: Operation code 2'b01 (write-one) pulls the line low from the first cycle after acceptance. The low time is 6 us at regular speed and 1 us at overdrive. The line is then released.
- R4: Operation code 2'b00 (write-zero) pulls the line low from slot start. The low time is 60 us at regular speed and 8 us at overdrive.
- R5: Operation codes 2'b10 and 2'b11 (read) pull the line low for the short time given in R3. The wire is then sampled as it stood 13 us (regular) or 1.5 us (overdrive) after slot start, counting the synchronizer delay. A high wire reads 1 and a low wire reads 0.
- R6: A slot lasts 65 us at regular speed and 10 us at overdrive. A recovery gap follows it, 5 us at regular speed or 2 us at overdrive, with `pull_low` at 0. `done` therefore comes exactly slot plus recovery cycles after acceptance.
- R7: `done` is high for exactly one cycle, in the first cycle in which `cmd_ready` is 1 again. `done_bit` carries the sampled bit for reads and is 0 for writes, whatever the wire does.
- R8: The speed select (`cmd_od`: 0 = regular, 1 = overdrive) is latched at acceptance. Changing it during a slot does not alter that slot's timing.
- R9: Applying reset in the middle of a slot releases the line and returns `cmd_ready` to 1 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | 00 write-zero, 01 write-one, 1x read |
| cmd_od | input | 1 | Speed select, 1 = overdrive |
| line_in | input | 1 | Wire level, asynchronous |
| pull_low | output | 1 | 1 = drive the wire low |
| done | output | 1 | One-cycle slot completion pulse |
| done_bit | output | 1 | Read result, 0 for writes |

## Verification
The bench builds the engine with `CLK_HZ` set to 10 MHz, so one microsecond is ten cycles. A regular slot plus its recovery then fits in 700 cycles, which keeps every operation at both speeds cheap to run while the timing windows stay clearly separated. At this resolution a simulated slave can release the wire exactly one cycle before or after the sampling point. Those two runs pin the sampling cycle and the synchronizer latency at both speeds.

// File: rtl/ow_slot_pkg.sv
// Shared types for the bit slot engine.
// Assumes: operation code bit 1 set means a read slot.
package ow_slot_pkg;
    typedef enum logic [1:0] {
        OP_WR0 = 2'b00,
        OP_WR1 = 2'b01,
        OP_RD  = 2'b10,
        OP_RD2 = 2'b11
    } slot_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_SLOT = 2'b01,
        ST_REC  = 2'b10
    } slot_state_e;
endpackage

// File: rtl/ow_line_sync.sv
// Multi-flop synchronizer for the asynchronous wire level.
// Assumes: the idle wire is high, so the flops reset to 1.
module ow_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the wire level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/ow_slot_timing.sv
// Maps the latched speed and operation to the cycle counts of one slot.
// Assumes: CLK_HZ is a whole number of MHz. SAMPLE_LAG is the extra delay
// of the synchronizer, and it is added to the sample point.
module ow_slot_timing #(
    parameter int CLK_HZ     = 125_000_000,
    parameter int SAMPLE_LAG = 2,
    parameter int CNT_W      = 16
) (
    input  logic             od,
    input  logic [1:0]       op,
    output logic [CNT_W-1:0] low_len,
    output logic [CNT_W-1:0] smp_at,
    output logic [CNT_W-1:0] slot_len,
    output logic [CNT_W-1:0] rec_len
);
    import ow_slot_pkg::*;

    localparam int CPU      = CLK_HZ / 1_000_000;
    localparam int R_SHORT  = 6 * CPU;
    localparam int R_ZERO   = 60 * CPU;
    localparam int R_SMP    = 13 * CPU;
    localparam int R_SLOT   = 65 * CPU;
    localparam int R_REC    = 5 * CPU;
    localparam int O_SHORT  = CPU;
    localparam int O_ZERO   = 8 * CPU;
    localparam int O_SMP    = (3 * CPU) / 2;
    localparam int O_SLOT   = 10 * CPU;
    localparam int O_REC    = 2 * CPU;

    // Select the phase lengths for the latched speed and operation.
    always_comb begin
        if (od) begin
            low_len  = (op == OP_WR0) ? CNT_W'(O_ZERO) : CNT_W'(O_SHORT);
            smp_at   = CNT_W'(O_SMP + SAMPLE_LAG);
            slot_len = CNT_W'(O_SLOT);
            rec_len  = CNT_W'(O_REC);
        end else begin
            low_len  = (op == OP_WR0) ? CNT_W'(R_ZERO) : CNT_W'(R_SHORT);
            smp_at   = CNT_W'(R_SMP + SAMPLE_LAG);
            slot_len = CNT_W'(R_SLOT);
            rec_len  = CNT_W'(R_REC);
        end
    end
endmodule

// File: rtl/ow_slot_engine.sv
// Master bit slot engine: one write-one, write-zero or read slot per
// accepted command, then a released recovery gap and a done pulse.
// Assumes: pull_low drives an external open-drain cell; line_in is async.
module ow_slot_engine #(
    parameter int CLK_HZ      = 125_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [1:0] cmd_op,
    input  logic       cmd_od,
    input  logic       line_in,
    output logic       pull_low,
    output logic       done,
    output logic       done_bit
);
    import ow_slot_pkg::*;

    localparam int REG_SLOT_CYC = 65 * (CLK_HZ / 1_000_000);
    localparam int CNT_W        = $clog2(REG_SLOT_CYC + SYNC_STAGES + 2) + 1;

    slot_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       op_q;
    logic             spd_q;
    logic             pull_q;
    logic             done_q;
    logic             rbit_q;
    logic             line_s;
    logic [CNT_W-1:0] low_len, smp_at, slot_len, rec_len;

    ow_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (line_in),
        .sync_out (line_s)
    );

    ow_slot_timing #(.CLK_HZ(CLK_HZ), .SAMPLE_LAG(SYNC_STAGES), .CNT_W(CNT_W)) tim_i (
        .od       (spd_q),
        .op       (op_q),
        .low_len  (low_len),
        .smp_at   (smp_at),
        .slot_len (slot_len),
        .rec_len  (rec_len)
    );

    // Sequence idle, slot and recovery phases and time each with one counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            op_q    <= OP_WR0;
            spd_q   <= 1'b0;
            pull_q  <= 1'b0;
            done_q  <= 1'b0;
            rbit_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        state_q <= ST_SLOT;
                        cnt_q   <= '0;
                        op_q    <= cmd_op;
                        spd_q   <= cmd_od;
                        pull_q  <= 1'b1;
                        rbit_q  <= 1'b0;
                    end
                end
                ST_SLOT: begin
                    cnt_q  <= cnt_q + 1'b1;
                    pull_q <= (cnt_q + 1'b1) < low_len;
                    if (op_q[1] && cnt_q == smp_at) rbit_q <= line_s;
                    if (cnt_q == slot_len - 1'b1) begin
                        state_q <= ST_REC;
                        cnt_q   <= '0;
                        pull_q  <= 1'b0;
                    end
                end
                ST_REC: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == rec_len - 1'b1) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cmd_ready = (state_q == ST_IDLE);
    assign pull_low  = pull_q;
    assign done      = done_q;
    assign done_bit  = done_q & rbit_q;

    // R2
    accept_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (pull_low && !cmd_ready));
    // R6
    pull_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pull_low |-> !cmd_ready);
    // R6
    rec_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REC) |-> !pull_low);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cmd_ready && !$past(cmd_ready)));
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    write_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !op_q[1]) |-> !done_bit);
    // R8
    speed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready ##1 !cmd_ready) |-> $stable(spd_q));
endmodule

// File: tb/ow_slot_engine_tb_top.sv
module ow_slot_engine_tb_top;
    localparam int CLK_HZ = 10_000_000;
    localparam int US     = CLK_HZ / 1_000_000;

    typedef struct packed {
        logic [1:0] op;
        logic       od;
        int         hold;
        int         low;
        int         tot;
        int         rbit;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'b01, 1'b0, 0,        6*US,  70*US, 0},
        '{2'b00, 1'b0, 0,        60*US, 70*US, 0},
        '{2'b10, 1'b0, 0,        6*US,  70*US, 1},
        '{2'b10, 1'b0, 20*US,    6*US,  70*US, 0},
        '{2'b10, 1'b0, 13*US+1,  6*US,  70*US, 0},
        '{2'b10, 1'b0, 13*US,    6*US,  70*US, 1},
        '{2'b11, 1'b0, 20*US,    6*US,  70*US, 0},
        '{2'b01, 1'b0, 20*US,    6*US,  70*US, 0},
        '{2'b01, 1'b1, 0,        1*US,  12*US, 0},
        '{2'b00, 1'b1, 0,        8*US,  12*US, 0},
        '{2'b10, 1'b1, 0,        1*US,  12*US, 1},
        '{2'b10, 1'b1, 3*US/2+1, 1*US,  12*US, 0},
        '{2'b10, 1'b1, 3*US/2,   1*US,  12*US, 1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [1:0] cmd_op = 2'b00;
    logic       cmd_od = 1'b0;
    logic       line_in;
    logic       pull_low;
    logic       done;
    logic       done_bit;
    int         hold_cyc = 0;
    int         k = 1_000_000;
    int         checks = 0;
    int         fails = 0;

    always #4 clk = ~clk;

    // Slave model: counts cycles since acceptance and holds the wire low
    // while k < hold_cyc.
    always @(posedge clk) begin
        if (cmd_valid && cmd_ready) k <= 0;
        else if (k < 1_000_000)     k <= k + 1;
    end
    assign line_in = !(pull_low || (k < hold_cyc));

    ow_slot_engine #(.CLK_HZ(CLK_HZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_od(cmd_od), .line_in(line_in),
        .pull_low(pull_low), .done(done), .done_bit(done_bit)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_slot(input logic [1:0] op, input logic od, input int hold,
                            input logic flip, output int low, output int tot,
                            output int rbit, output int rdy_hi);
        @(negedge clk);
        cmd_op = op; cmd_od = od; hold_cyc = hold; cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op = ~op;
        if (flip) cmd_od = ~od;
        low = 0; tot = 0; rdy_hi = 0; rbit = -1;
        forever begin
            if (done) begin
                rbit = int'(done_bit);
                break;
            end
            tot++;
            if (pull_low) low++;
            if (cmd_ready) rdy_hi++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int low, tot, rbit, rdy;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "ready", int'(cmd_ready), 1);
        chk("R1", "pull_low", int'(pull_low), 0);
        chk("R1", "done", int'(done), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = (VECS[i].op == 2'b00) ? "R4" : (VECS[i].op == 2'b01) ? "R3" : "R5";
            run_slot(VECS[i].op, VECS[i].od, VECS[i].hold, 1'b0, low, tot, rbit, rdy);
            chk(rq, "low time", low, VECS[i].low);
            chk("R6", "slot+recovery", tot, VECS[i].tot);
            chk(VECS[i].op[1] ? "R5" : "R7", "done_bit", rbit, VECS[i].rbit);
            chk("R2", "ready high while busy", rdy, 0);
            chk("R7", "ready with done", int'(cmd_ready), 1);
            @(negedge clk);
            chk("R7", "done one cycle", int'(done), 0);
        end

        // R8 speed flipped to overdrive after acceptance: regular timing kept
        run_slot(2'b00, 1'b0, 0, 1'b1, low, tot, rbit, rdy);
        chk("R8", "low time after flip", low, 60*US);
        chk("R8", "total after flip", tot, 70*US);

        // R8 speed flipped to regular mid overdrive slot
        run_slot(2'b01, 1'b1, 0, 1'b1, low, tot, rbit, rdy);
        chk("R8", "od total after flip", tot, 12*US);

        // R9 reset mid-slot
        @(negedge clk);
        cmd_op = 2'b00; cmd_od = 1'b0; hold_cyc = 0; cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (100) @(negedge clk);
        chk("R9", "pull before reset", int'(pull_low), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9", "pull after reset", int'(pull_low), 0);
        chk("R9", "ready after reset", int'(cmd_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 valid held low: no slot starts
        repeat (20) @(negedge clk);
        chk("R2", "idle pull without valid", int'(pull_low), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule